// File: doc/BRIEF.md
# Parity-Protected Cache Data Array

This block holds the data half of a small cache. Each line has a fixed number of words, and every byte carries one stored even-parity bit. Two write paths change the array. A store writes selected bytes of one word, or clears a whole line when it is a zeroing store. A fill loads a complete line. Both paths recompute parity for exactly the bytes they write.

Two read paths return data one clock after the request. A load-hit read returns one word. A castout read returns the whole line. When the check enable is high, each read compares the stored parity of the bytes it returns against parity recomputed from those bytes. A mismatch produces a one-cycle machine-check request that carries the line index and the read path that caused it.

Hit, castout and replacement decisions are made outside the block. A test-only injection input corrupts the parity bit of one chosen byte as it is written, so that error detection can be exercised.

Top module: `cpar_data_array`

## Requirements
- R1: After reset all outputs are low and every line reads as zero with consistent parity, so a checked read of any line raises no error.
- R2: A store with `st_zero` low writes only the bytes of word `st_word` whose `st_be` bit is set. Byte k of a word is bits [8k+7:8k] of that word, and word w of a line is bits [32w+31:32w]. All other bytes of the line keep their data and parity.
- R3: A store with `st_zero` high writes zero to every byte of line `st_index`, with matching parity.
- R4: A fill replaces the whole line `fill_index` with `fill_line` and rewrites all of its parity bits, which clears any earlier parity corruption in that line.
- R5: A load presented in cycle t gives `ld_valid` high and word `ld_word` of line `ld_index` on `ld_data` in cycle t+1. The word is taken from the contents before any write made in cycle t.
- R6: A castout presented in cycle t gives `co_valid` high and the whole line on `co_line` in cycle t+1. The contents are those before any write made in cycle t, and the parity of every byte of the line is checked.
- R7: When `chk_en` is low in the cycle a read is presented, `err_pulse` stays low for that read, even if the stored parity is wrong.
- R8: A load with `chk_en` high whose word has at least one byte with wrong parity raises `err_pulse` for exactly the cycle in which `ld_valid` is high. In that cycle `err_index` equals `ld_index` and `err_castout` is 0.
- R9: A castout with `chk_en` high whose line has any byte with wrong parity raises `err_pulse` with `err_castout` = 1 and `err_index` equal to `co_index`. If a load error and a castout error occur in the same cycle, the castout is the one reported. While `err_pulse` is low, `err_index` and `err_castout` are zero.
- R10: With `inj_en` high, the parity bit stored for byte `inj_byte` of word `inj_word` is inverted, but only in a line written in that cycle and only if that byte is written. A later write of that byte without injection restores correct parity.
- R11: If a fill and a store target the same line in the same cycle, the fill is applied and the store is discarded entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Parity check enable for reads in this cycle |
| st_en | input | 1 | Store write request |
| st_zero | input | 1 | Store clears the whole line |
| st_index | input | 4 | Store line index |
| st_word | input | 2 | Store word within line |
| st_be | input | 4 | Store byte enables within the word |
| st_data | input | 32 | Store data |
| fill_en | input | 1 | Line fill request |
| fill_index | input | 4 | Fill line index |
| fill_line | input | 128 | Fill data |
| inj_en | input | 1 | Test-only parity inversion on this cycle's writes |
| inj_word | input | 2 | Word holding the byte to corrupt |
| inj_byte | input | 2 | Byte within that word to corrupt |
| ld_en | input | 1 | Load-hit read request |
| ld_index | input | 4 | Load line index |
| ld_word | input | 2 | Load word within line |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | 32 | Load data |
| co_en | input | 1 | Castout read request |
| co_index | input | 4 | Castout line index |
| co_valid | output | 1 | Castout data valid |
| co_line | output | 128 | Castout line data |
| err_pulse | output | 1 | Machine-check request, one cycle |
| err_index | output | 4 | Line index of the failing read |
| err_castout | output | 1 | 1 when the castout caused the error, 0 for the load |

## Verification
A fill and a store can hit the same line in one clock, and so can a failing load and a failing castout. The bench drives the first case directly with different data on each path, then reads the line back to confirm that only the fill data is present. It provokes the second case by corrupting two lines, reading both in one cycle, and expecting the castout index and flag. Random traffic over a narrow index range causes further collisions. A bench model applies the fill-over-store priority, and every read result is judged against that model.

// File: rtl/cpar_pkg.sv
package cpar_pkg;

    localparam int CP_LINES   = 16;
    localparam int CP_WORDS   = 4;
    localparam int CP_WBYTES  = 4;

    localparam int CP_IDX_W   = $clog2(CP_LINES);
    localparam int CP_WSEL_W  = $clog2(CP_WORDS);
    localparam int CP_BSEL_W  = $clog2(CP_WBYTES);
    localparam int CP_WORD_W  = 8 * CP_WBYTES;
    localparam int CP_LBYTES  = CP_WORDS * CP_WBYTES;
    localparam int CP_LINE_W  = 8 * CP_LBYTES;

    typedef logic [CP_LINE_W-1:0] line_t;
    typedef logic [CP_LBYTES-1:0] lmask_t;
    typedef logic [CP_IDX_W-1:0]  idx_t;
    typedef logic [CP_WORD_W-1:0] word_t;

    typedef enum logic {
        ERR_FROM_LOAD    = 1'b0,
        ERR_FROM_CASTOUT = 1'b1
    } err_src_e;

    typedef struct packed {
        logic   en;
        idx_t   idx;
        line_t  data;
        lmask_t bmask;
        lmask_t inv;
    } wr_req_t;

    // Even parity of each byte of a line.
    function automatic lmask_t line_parity(line_t d);
        lmask_t p;
        for (int b = 0; b < CP_LBYTES; b++) begin
            p[b] = ^d[b*8 +: 8];
        end
        return p;
    endfunction

    // Widen a per-byte mask to a per-bit mask.
    function automatic line_t byte_to_bit(lmask_t m);
        line_t r;
        for (int b = 0; b < CP_LBYTES; b++) begin
            r[b*8 +: 8] = {8{m[b]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/cpar_wr_req.sv
module cpar_wr_req
    import cpar_pkg::*;
(
    input  logic                 st_en,
    input  logic                 st_zero,
    input  idx_t                 st_index,
    input  logic [CP_WSEL_W-1:0] st_word,
    input  logic [CP_WBYTES-1:0] st_be,
    input  word_t                st_data,
    input  logic                 fill_en,
    input  idx_t                 fill_index,
    input  line_t                fill_line,
    input  logic                 inj_en,
    input  logic [CP_WSEL_W-1:0] inj_word,
    input  logic [CP_BSEL_W-1:0] inj_byte,
    output wr_req_t              st_req,
    output wr_req_t              fill_req
);
    lmask_t inj_mask;
    lmask_t st_mask;

    always_comb begin
        inj_mask = '0;
        if (inj_en) begin
            inj_mask = lmask_t'(1) << (int'(inj_word) * CP_WBYTES + int'(inj_byte));
        end
        st_mask = st_zero ? '1
                : (lmask_t'(st_be) << (int'(st_word) * CP_WBYTES));
    end

    always_comb begin
        st_req.en    = st_en;
        st_req.idx   = st_index;
        st_req.data  = st_zero ? '0 : {CP_WORDS{st_data}};
        st_req.bmask = st_mask;
        st_req.inv   = inj_mask & st_mask;

        fill_req.en    = fill_en;
        fill_req.idx   = fill_index;
        fill_req.data  = fill_line;
        fill_req.bmask = '1;
        fill_req.inv   = inj_mask;
    end
endmodule

// File: rtl/cpar_store.sv
module cpar_store
    import cpar_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t fill_req,
    input  wr_req_t st_req,
    input  idx_t    ld_idx,
    input  idx_t    co_idx,
    output line_t   ld_line,
    output lmask_t  ld_par,
    output line_t   co_data,
    output lmask_t  co_par
);
    line_t  rd_data [CP_LINES];
    lmask_t rd_par  [CP_LINES];
    line_t  st_bits;

    assign st_bits = byte_to_bit(st_req.bmask);

    for (genvar i = 0; i < CP_LINES; i++) begin : g_line
        line_t  q_data;
        lmask_t q_par;
        line_t  merged;
        lmask_t merged_par;
        logic   fill_hit;
        logic   st_hit;

        assign fill_hit   = fill_req.en && (fill_req.idx == idx_t'(i));
        assign st_hit     = st_req.en && (st_req.idx == idx_t'(i));
        assign merged     = (q_data & ~st_bits) | (st_req.data & st_bits);
        assign merged_par = (q_par & ~st_req.bmask)
                          | ((line_parity(merged) ^ st_req.inv) & st_req.bmask);

        always_ff @(posedge clk) begin
            if (rst) begin
                q_data <= '0;
                q_par  <= '0;
            end else if (fill_hit) begin
                q_data <= fill_req.data;
                q_par  <= line_parity(fill_req.data) ^ fill_req.inv;
            end else if (st_hit) begin
                q_data <= merged;
                q_par  <= merged_par;
            end
        end

        assign rd_data[i] = q_data;
        assign rd_par[i]  = q_par;
    end

    assign ld_line = rd_data[ld_idx];
    assign ld_par  = rd_par[ld_idx];
    assign co_data = rd_data[co_idx];
    assign co_par  = rd_par[co_idx];
endmodule

// File: rtl/cpar_check.sv
module cpar_check
    import cpar_pkg::*;
(
    input  line_t  data,
    input  lmask_t par,
    input  lmask_t sel,
    output logic   bad
);
    assign bad = |((line_parity(data) ^ par) & sel);
endmodule

// File: rtl/cpar_data_array.sv
module cpar_data_array
    import cpar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  chk_en,
    input  logic                  st_en,
    input  logic                  st_zero,
    input  logic [CP_IDX_W-1:0]   st_index,
    input  logic [CP_WSEL_W-1:0]  st_word,
    input  logic [CP_WBYTES-1:0]  st_be,
    input  logic [CP_WORD_W-1:0]  st_data,
    input  logic                  fill_en,
    input  logic [CP_IDX_W-1:0]   fill_index,
    input  logic [CP_LINE_W-1:0]  fill_line,
    input  logic                  inj_en,
    input  logic [CP_WSEL_W-1:0]  inj_word,
    input  logic [CP_BSEL_W-1:0]  inj_byte,
    input  logic                  ld_en,
    input  logic [CP_IDX_W-1:0]   ld_index,
    input  logic [CP_WSEL_W-1:0]  ld_word,
    output logic                  ld_valid,
    output logic [CP_WORD_W-1:0]  ld_data,
    input  logic                  co_en,
    input  logic [CP_IDX_W-1:0]   co_index,
    output logic                  co_valid,
    output logic [CP_LINE_W-1:0]  co_line,
    output logic                  err_pulse,
    output logic [CP_IDX_W-1:0]   err_index,
    output logic                  err_castout
);
    wr_req_t  st_req, fill_req;
    line_t    ld_line, co_data;
    lmask_t   ld_par, co_par, ld_sel;
    logic     ld_bad, co_bad, ld_err, co_err;
    err_src_e err_src_q;

    cpar_wr_req u_req (
        .st_en      (st_en),
        .st_zero    (st_zero),
        .st_index   (st_index),
        .st_word    (st_word),
        .st_be      (st_be),
        .st_data    (st_data),
        .fill_en    (fill_en),
        .fill_index (fill_index),
        .fill_line  (fill_line),
        .inj_en     (inj_en),
        .inj_word   (inj_word),
        .inj_byte   (inj_byte),
        .st_req     (st_req),
        .fill_req   (fill_req)
    );

    cpar_store u_store (
        .clk      (clk),
        .rst      (rst),
        .fill_req (fill_req),
        .st_req   (st_req),
        .ld_idx   (ld_index),
        .co_idx   (co_index),
        .ld_line  (ld_line),
        .ld_par   (ld_par),
        .co_data  (co_data),
        .co_par   (co_par)
    );

    assign ld_sel = lmask_t'({CP_WBYTES{1'b1}}) << (int'(ld_word) * CP_WBYTES);

    cpar_check u_ld_chk (.data(ld_line), .par(ld_par), .sel(ld_sel), .bad(ld_bad));
    cpar_check u_co_chk (.data(co_data), .par(co_par), .sel('1),     .bad(co_bad));

    assign ld_err = chk_en && ld_en && ld_bad;
    assign co_err = chk_en && co_en && co_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid  <= 1'b0;
            ld_data   <= '0;
            co_valid  <= 1'b0;
            co_line   <= '0;
            err_pulse <= 1'b0;
            err_index <= '0;
            err_src_q <= ERR_FROM_LOAD;
        end else begin
            ld_valid <= ld_en;
            co_valid <= co_en;
            if (ld_en) ld_data <= ld_line[int'(ld_word) * CP_WORD_W +: CP_WORD_W];
            if (co_en) co_line <= co_data;
            err_pulse <= ld_err || co_err;
            if (co_err) begin
                err_index <= co_index;
                err_src_q <= ERR_FROM_CASTOUT;
            end else if (ld_err) begin
                err_index <= ld_index;
                err_src_q <= ERR_FROM_LOAD;
            end else begin
                err_index <= '0;
                err_src_q <= ERR_FROM_LOAD;
            end
        end
    end

    assign err_castout = (err_src_q == ERR_FROM_CASTOUT);
endmodule

// File: rtl/cpar_data_array_chk.sv
module cpar_data_array_chk
    import cpar_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  chk_en,
    input logic                  ld_en,
    input logic [CP_IDX_W-1:0]   ld_index,
    input logic                  ld_valid,
    input logic                  co_en,
    input logic [CP_IDX_W-1:0]   co_index,
    input logic                  co_valid,
    input logic                  err_pulse,
    input logic [CP_IDX_W-1:0]   err_index,
    input logic                  err_castout
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !err_pulse && !ld_valid && !co_valid);

    p_ld_valid_r5: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> ld_valid);

    p_co_valid_r6: assert property (@(posedge clk) disable iff (rst)
        co_en |=> co_valid);

    p_gated_off_r7: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> !err_pulse);

    p_load_err_r8: assert property (@(posedge clk) disable iff (rst)
        err_pulse && !err_castout |-> $past(ld_en) && ld_valid && err_index == $past(ld_index));

    p_castout_err_r9: assert property (@(posedge clk) disable iff (rst)
        err_pulse && err_castout |-> $past(co_en) && co_valid && err_index == $past(co_index));

    p_idle_fields_r9: assert property (@(posedge clk) disable iff (rst)
        !err_pulse |-> err_index == '0 && !err_castout);
endmodule

bind cpar_data_array cpar_data_array_chk u_chk (.*);

// File: tb/cpar_data_array_bench.sv
module cpar_data_array_bench;
    import cpar_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic chk_en, st_en, st_zero, fill_en, inj_en, ld_en, co_en;
    logic [CP_IDX_W-1:0]  st_index, fill_index, ld_index, co_index;
    logic [CP_WSEL_W-1:0] st_word, inj_word, ld_word;
    logic [CP_BSEL_W-1:0] inj_byte;
    logic [CP_WBYTES-1:0] st_be;
    logic [CP_WORD_W-1:0] st_data;
    logic [CP_LINE_W-1:0] fill_line;
    logic                 ld_valid, co_valid, err_pulse, err_castout;
    logic [CP_WORD_W-1:0] ld_data;
    logic [CP_LINE_W-1:0] co_line;
    logic [CP_IDX_W-1:0]  err_index;

    int checks = 0;
    int failures = 0;

    logic [CP_LINE_W-1:0] mdata [CP_LINES];
    logic [CP_LBYTES-1:0] mbad  [CP_LINES];

    logic                 e_ldv, e_cov, e_err, e_cast;
    logic [CP_WORD_W-1:0] e_ld;
    logic [CP_LINE_W-1:0] e_co;
    logic [CP_IDX_W-1:0]  e_idx;

    always #10 clk = ~clk;

    cpar_data_array u_cpar_data_array (.*);

    task automatic check(bit ok, string req, string what, logic [CP_LINE_W-1:0] act,
                         logic [CP_LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic word_bad(logic [CP_LBYTES-1:0] b, int w);
        return |((b >> (w * CP_WBYTES)) & CP_LBYTES'({CP_WBYTES{1'b1}}));
    endfunction

    task automatic idle();
        chk_en = 0; st_en = 0; st_zero = 0; fill_en = 0; inj_en = 0; ld_en = 0; co_en = 0;
        st_index = 0; fill_index = 0; ld_index = 0; co_index = 0;
        st_word = 0; inj_word = 0; ld_word = 0; inj_byte = 0; st_be = 0;
        st_data = 0; fill_line = 0;
    endtask

    // Inputs are already driven; compute expectations, update model, clock, check.
    task automatic run_cycle(string tag);
        logic ld_b, co_b;
        logic [CP_LBYTES-1:0] im, bm;
        e_ldv = ld_en;
        e_cov = co_en;
        e_ld  = mdata[ld_index][int'(ld_word) * CP_WORD_W +: CP_WORD_W];
        e_co  = mdata[co_index];
        ld_b  = chk_en && ld_en && word_bad(mbad[ld_index], int'(ld_word));
        co_b  = chk_en && co_en && (mbad[co_index] != 0);
        e_err = ld_b || co_b;
        e_cast = co_b;
        e_idx = co_b ? co_index : (ld_b ? ld_index : '0);

        im = inj_en ? (CP_LBYTES'(1) << (int'(inj_word) * CP_WBYTES + int'(inj_byte))) : '0;
        if (st_en && !(fill_en && fill_index == st_index)) begin
            bm = st_zero ? '1 : (CP_LBYTES'(st_be) << (int'(st_word) * CP_WBYTES));
            for (int b = 0; b < CP_LBYTES; b++) begin
                if (bm[b]) begin
                    mdata[st_index][b*8 +: 8] = st_zero ? 8'h00 : st_data[(b % CP_WBYTES)*8 +: 8];
                    mbad[st_index][b] = im[b];
                end
            end
        end
        if (fill_en) begin
            mdata[fill_index] = fill_line;
            mbad[fill_index]  = im;
        end

        @(negedge clk);
        check(ld_valid == e_ldv, tag, "ld_valid", CP_LINE_W'(ld_valid), CP_LINE_W'(e_ldv));
        if (e_ldv) check(ld_data == e_ld, tag, "ld_data", CP_LINE_W'(ld_data), CP_LINE_W'(e_ld));
        check(co_valid == e_cov, tag, "co_valid", CP_LINE_W'(co_valid), CP_LINE_W'(e_cov));
        if (e_cov) check(co_line == e_co, tag, "co_line", co_line, e_co);
        check(err_pulse == e_err, tag, "err_pulse", CP_LINE_W'(err_pulse), CP_LINE_W'(e_err));
        check(err_index == e_idx && err_castout == e_cast, tag, "err_index/castout",
              CP_LINE_W'({err_index, err_castout}), CP_LINE_W'({e_idx, e_cast}));
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < CP_LINES; i++) begin
            mdata[i] = '0;
            mbad[i]  = '0;
        end
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1: outputs low while in reset
        check(!ld_valid && !co_valid && !err_pulse && err_index == 0 && !err_castout,
              "R1", "reset outputs", CP_LINE_W'({ld_valid, co_valid, err_pulse}), '0);
        rst = 0;
        // R1: checked reads of fresh lines are zero and clean
        chk_en = 1; ld_en = 1; ld_index = 3; ld_word = 2; co_en = 1; co_index = 11;
        run_cycle("R1");
        idle();

        // R4: fill, then read back
        fill_en = 1; fill_index = 2;
        fill_line = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
        run_cycle("R4");
        idle(); ld_en = 1; ld_index = 2; ld_word = 3; chk_en = 1;
        run_cycle("R4");

        // R2: byte-masked store
        idle(); st_en = 1; st_index = 2; st_word = 1; st_be = 4'b0101; st_data = 32'haabbccdd;
        run_cycle("R2");
        idle(); co_en = 1; co_index = 2; chk_en = 1;
        run_cycle("R2");

        // R5: same-cycle load and store return the old word
        idle(); st_en = 1; st_index = 2; st_word = 0; st_be = 4'hf; st_data = 32'h12345678;
        ld_en = 1; ld_index = 2; ld_word = 0;
        run_cycle("R5");
        idle(); ld_en = 1; ld_index = 2; ld_word = 0;
        run_cycle("R5");

        // R3: zeroing store, castout sees zeros without error
        idle(); st_en = 1; st_zero = 1; st_index = 2; st_word = 3; st_be = 4'h1;
        st_data = 32'hffffffff;
        run_cycle("R3");
        idle(); co_en = 1; co_index = 2; chk_en = 1;
        run_cycle("R3");

        // R10: injected fill on line 5 (word 0 byte 2), line 7 (word 3 byte 0)
        idle(); fill_en = 1; fill_index = 5; fill_line = 128'h11223344_55667788_99aabbcc_ddeeff00;
        inj_en = 1; inj_word = 0; inj_byte = 2;
        run_cycle("R10");
        idle(); fill_en = 1; fill_index = 7; fill_line = 128'hcafef00d_deadbeef_01234567_89abcdef;
        inj_en = 1; inj_word = 3; inj_byte = 0;
        run_cycle("R10");

        // R7: checking off hides the corruption
        idle(); ld_en = 1; ld_index = 5; ld_word = 0; co_en = 1; co_index = 7;
        run_cycle("R7");

        // R8: checked load of the corrupted word
        idle(); chk_en = 1; ld_en = 1; ld_index = 5; ld_word = 0;
        run_cycle("R8");
        // R8: clean word of the same line gives no error
        idle(); chk_en = 1; ld_en = 1; ld_index = 5; ld_word = 1;
        run_cycle("R8");

        // R6: castout checks every word
        idle(); chk_en = 1; co_en = 1; co_index = 7;
        run_cycle("R6");

        // R9: both reads fail together, castout reported
        idle(); chk_en = 1; ld_en = 1; ld_index = 5; ld_word = 0; co_en = 1; co_index = 7;
        run_cycle("R9");

        // R10: injection on a byte the store does not write has no effect
        idle(); st_en = 1; st_index = 2; st_word = 1; st_be = 4'b0001; st_data = 32'h5a5a5a5a;
        inj_en = 1; inj_word = 1; inj_byte = 3;
        run_cycle("R10");
        idle(); chk_en = 1; co_en = 1; co_index = 2;
        run_cycle("R10");
        // R10: rewriting the bad byte cleanly restores parity
        idle(); st_en = 1; st_index = 5; st_word = 0; st_be = 4'b0100; st_data = 32'h00770000;
        run_cycle("R10");
        idle(); chk_en = 1; ld_en = 1; ld_index = 5; ld_word = 0;
        run_cycle("R10");

        // R4: fill clears corruption on line 7
        idle(); fill_en = 1; fill_index = 7; fill_line = {4{32'h01020304}};
        run_cycle("R4");
        idle(); chk_en = 1; co_en = 1; co_index = 7;
        run_cycle("R4");

        // R11: fill and store to the same line, fill wins
        idle(); fill_en = 1; fill_index = 9; fill_line = {4{32'h89abcdef}};
        st_en = 1; st_index = 9; st_word = 2; st_be = 4'hf; st_data = 32'h00000000;
        inj_en = 0;
        run_cycle("R11");
        idle(); chk_en = 1; co_en = 1; co_index = 9;
        run_cycle("R11");
        // R11: zeroing store also loses to a fill
        idle(); fill_en = 1; fill_index = 9; fill_line = {4{32'h13572468}};
        st_en = 1; st_zero = 1; st_index = 9;
        run_cycle("R11");
        idle(); co_en = 1; co_index = 9;
        run_cycle("R11");

        // Random traffic over a narrow index range
        for (int n = 0; n < 3000; n++) begin
            chk_en     = ($urandom % 4) != 0;
            st_en      = ($urandom % 2) == 1;
            st_zero    = ($urandom % 16) == 0;
            st_index   = CP_IDX_W'($urandom % 6);
            st_word    = CP_WSEL_W'($urandom);
            st_be      = CP_WBYTES'($urandom);
            st_data    = $urandom;
            fill_en    = ($urandom % 4) == 0;
            fill_index = CP_IDX_W'($urandom % 6);
            fill_line  = {$urandom, $urandom, $urandom, $urandom};
            inj_en     = ($urandom % 8) == 0;
            inj_word   = CP_WSEL_W'($urandom);
            inj_byte   = CP_BSEL_W'($urandom);
            ld_en      = ($urandom % 2) == 1;
            ld_index   = CP_IDX_W'($urandom % 6);
            ld_word    = CP_WSEL_W'($urandom);
            co_en      = ($urandom % 3) == 0;
            co_index   = CP_IDX_W'($urandom % 6);
            run_cycle("R5");
        end

        idle();
        run_cycle("R1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule